// File: doc/BRIEF.md
# E1 Sa-Bit Codeword Inserter

This block sits on the transmit side of an E1 framer, just before the timeslot-0 byte reaches the line. On every timeslot-0 byte of a non-alignment frame it can overwrite one chosen national (Sa) bit with one bit of a 4-bit codeword. Within each 8-frame half of the 16-frame CRC-4 multiframe, the four odd (non-alignment) frames carry codeword bits 1, 2, 3 and 4 in that order. Each codeword bit has its own enable. An enable of 0 lets the national bit pass through unchanged.

A small write port holds the codeword, the four enables, the Sa position selector and two disable controls. The framer presents each outgoing timeslot-0 byte with a strobe and its 4-bit frame number (0 to 15; bit 3 is 0 in the first half and 1 in the second). A new codeword first goes into a shadow register. It becomes live at the start of the half that follows the half in which it was written. A write in the first half therefore shows up in the second half of the same multiframe, and a write in the second half shows up in the first half of the next multiframe. The enables, the selector and the disables act at once. The modified byte comes out one clock after its strobe.

Top module: `sa_cw_inserter`

## Requirements
- R1: After reset, `ts0_out` is 0 and `ts0_out_vld` is 0. The live codeword and all four enables are 0, so bytes pass through unchanged.
- R2: For an odd frame number f, with the selector in range, no disable set and the enable of codeword bit k = f[2:1]+1 set, the output equals the input byte with the selected bit replaced by live codeword bit k. All other seven bits are unchanged. Codeword bit k is `reg_wdata[4-k]` of a write to address 0.
- R3: The enable of codeword bit k is `reg_wdata[4-k]` of a write to address 1. When that enable is 0, the byte of the frame carrying bit k passes through unchanged.
- R4: Bytes strobed with an even frame number always pass through unchanged.
- R5: The selector is `reg_wdata[2:0]` of a write to address 2. Values 0, 1, 2, 3 and 4 pick byte bits [4], [3], [2], [1] and [0] (Sa4 to Sa8, where [7] is the first bit sent). Values 5 to 7 disable insertion.
- R6: Insertion happens only when both the frame disable (`reg_wdata[3]` at address 2) and the insertion disable (`reg_wdata[4]` at address 2) are 0.
- R7: A codeword written while the last strobed frame was in the first half (frames 0 to 7) goes live on the strobe of frame 8. The odd frames that remain in the first half still carry the previous codeword.
- R8: A codeword written while the last strobed frame was in the second half goes live on the strobe of frame 0. The odd frames that remain in the second half still carry the previous codeword.
- R9: A codeword write in the same cycle as the strobe of frame 0 or frame 8 counts as written in the half that is ending. It goes live on that strobe, so the next odd frame already carries it.
- R10: When several codeword writes fall in one half, only the last one goes live.
- R11: `ts0_out_vld` is high exactly in the cycle after a strobe, and `ts0_out` then holds that strobe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts0_stb | input | 1 | A timeslot-0 byte is presented this cycle |
| ts0_frm | input | 4 | Frame number within the CRC-4 multiframe; bit 3 selects the half |
| ts0_in | input | 8 | Outgoing timeslot-0 byte, bit 7 sent first |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 codeword, 1 enables, 2 control |
| reg_wdata | input | 5 | Register write data |
| ts0_out | output | 8 | Timeslot-0 byte after insertion |
| ts0_out_vld | output | 1 | `ts0_out` carries a new result |

## Verification
A codeword write and the strobe of the first frame of a half can land on the same clock edge. In that case the shadow load and the hand-over to the live codeword coincide. The bench forces this case by driving a codeword write and the frame-8 strobe on the same edge. It then judges the outcome from the following odd frames, which must already carry the new codeword. A second case stacks two writes inside one half and checks that only the later one appears after the boundary. Dedicated cases also confirm that odd frames between a write and its boundary keep the old codeword in both halves.

// File: rtl/sa_cw_pkg.sv
package sa_cw_pkg;

    localparam int CW_BITS  = 4;
    localparam int CW_IDX_W = $clog2(CW_BITS);
    localparam int BYTE_W   = 8;
    localparam int FRM_W    = 4;
    localparam int POS_W    = FRM_W - 1;
    localparam int SEL_W    = 3;
    localparam int SA_FIRST = 4;
    localparam int SA_LAST  = 8;
    localparam int REG_AW   = 2;
    localparam int REG_DW   = 5;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CODE = 2'd0,
        ADDR_ENAB = 2'd1,
        ADDR_CTRL = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic               frm_dis;
        logic               ins_dis;
        logic [CW_BITS-1:0] en;
    } sa_cfg_t;

    typedef struct packed {
        logic              vld;
        logic [POS_W-1:0]  pos;
        logic [BYTE_W-1:0] data;
    } ts0_beat_t;

    function automatic logic sel_ok(input logic [SEL_W-1:0] s);
        return s <= SEL_W'(SA_LAST - SA_FIRST);
    endfunction

    function automatic logic [BYTE_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
        logic [BYTE_W-1:0] m;
        m = '0;
        if (sel_ok(s))
            m = BYTE_W'(1) << (SEL_W'(BYTE_W - SA_FIRST) - s);
        return m;
    endfunction

    function automatic logic [CW_IDX_W-1:0] cw_index(input logic [POS_W-1:0] pos);
        return CW_IDX_W'(CW_BITS - 1) - CW_IDX_W'(pos[POS_W-1:1]);
    endfunction

    function automatic logic half_start(input logic [POS_W-1:0] pos);
        return pos == '0;
    endfunction

endpackage

// File: rtl/sa_cfg_regs.sv
module sa_cfg_regs
    import sa_cw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output sa_cfg_t               cfg,
    output logic                  cw_wr,
    output logic [CW_BITS-1:0]    cw_wdata
);

    reg_addr_e addr_e;

    always_comb begin
        addr_e   = reg_addr_e'(reg_addr);
        cw_wr    = reg_wr && (addr_e == ADDR_CODE);
        cw_wdata = reg_wdata[CW_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (addr_e)
                ADDR_ENAB: cfg.en <= reg_wdata[CW_BITS-1:0];
                ADDR_CTRL: begin
                    cfg.sel     <= reg_wdata[SEL_W-1:0];
                    cfg.frm_dis <= reg_wdata[SEL_W];
                    cfg.ins_dis <= reg_wdata[SEL_W+1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sa_cw_shadow.sv
module sa_cw_shadow
    import sa_cw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cw_wr,
    input  logic [CW_BITS-1:0]    cw_wdata,
    input  logic                  stb,
    input  logic [FRM_W-1:0]      frm,
    output logic [CW_BITS-1:0]    active
);

    logic [CW_BITS-1:0] shadow_q, shadow_n;
    logic               pend_q, pend_n;
    logic               tgt_q, tgt_n;
    logic               cur_half_q;
    logic               frm_half;
    logic               load;

    always_comb begin
        frm_half = frm[FRM_W-1];
        shadow_n = cw_wr ? cw_wdata : shadow_q;
        pend_n   = cw_wr | pend_q;
        tgt_n    = cw_wr ? ~cur_half_q : tgt_q;
        load     = stb && half_start(frm[POS_W-1:0]) && pend_n && (frm_half == tgt_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            pend_q     <= 1'b0;
            tgt_q      <= 1'b0;
            cur_half_q <= 1'b1;
            active     <= '0;
        end else begin
            shadow_q <= shadow_n;
            tgt_q    <= tgt_n;
            pend_q   <= pend_n & ~load;
            if (load)
                active <= shadow_n;
            if (stb)
                cur_half_q <= frm_half;
        end
    end

endmodule

// File: rtl/sa_bit_mux.sv
module sa_bit_mux
    import sa_cw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  ts0_beat_t             beat,
    input  sa_cfg_t               cfg,
    input  logic [CW_BITS-1:0]    active,
    output logic [BYTE_W-1:0]     ts0_out,
    output logic                  ts0_out_vld
);

    logic [CW_IDX_W-1:0] idx;
    logic [BYTE_W-1:0]   mask;
    logic                ins;
    logic [BYTE_W-1:0]   nxt;

    always_comb begin
        idx  = cw_index(beat.pos);
        mask = sel_mask(cfg.sel);
        ins  = beat.pos[0] && !cfg.frm_dis && !cfg.ins_dis && cfg.en[idx];
        nxt  = beat.data;
        if (ins)
            nxt = (beat.data & ~mask) | (active[idx] ? mask : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts0_out     <= '0;
            ts0_out_vld <= 1'b0;
        end else begin
            ts0_out_vld <= beat.vld;
            if (beat.vld)
                ts0_out <= nxt;
        end
    end

endmodule

// File: rtl/sa_cw_inserter.sv
module sa_cw_inserter
    import sa_cw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ts0_stb,
    input  logic [FRM_W-1:0]      ts0_frm,
    input  logic [BYTE_W-1:0]     ts0_in,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     ts0_out,
    output logic                  ts0_out_vld
);

    sa_cfg_t            cfg_q;
    logic               cw_wr;
    logic [CW_BITS-1:0] cw_wdata;
    logic [CW_BITS-1:0] cw_active;
    ts0_beat_t          beat;

    always_comb begin
        beat.vld  = ts0_stb;
        beat.pos  = ts0_frm[POS_W-1:0];
        beat.data = ts0_in;
    end

    sa_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cfg       (cfg_q),
        .cw_wr     (cw_wr),
        .cw_wdata  (cw_wdata)
    );

    sa_cw_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .cw_wr    (cw_wr),
        .cw_wdata (cw_wdata),
        .stb      (ts0_stb),
        .frm      (ts0_frm),
        .active   (cw_active)
    );

    sa_bit_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .beat        (beat),
        .cfg         (cfg_q),
        .active      (cw_active),
        .ts0_out     (ts0_out),
        .ts0_out_vld (ts0_out_vld)
    );

endmodule

// File: rtl/sa_cw_inserter_chk.sv
module sa_cw_inserter_chk
    import sa_cw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ts0_stb,
    input  logic [POS_W-1:0]      frm_pos,
    input  logic [BYTE_W-1:0]     ts0_in,
    input  logic [BYTE_W-1:0]     ts0_out,
    input  logic                  ts0_out_vld,
    input  sa_cfg_t               cfg,
    input  logic [CW_BITS-1:0]    active
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ts0_out_vld && ts0_out == '0));

    // R11
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ts0_stb |=> ts0_out_vld);

    // R11
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ts0_stb |=> !ts0_out_vld);

    // R4
    even_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ts0_stb && !frm_pos[0]) |=> (ts0_out == $past(ts0_in)));

    // R6
    dis_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ts0_stb && (cfg.frm_dis || cfg.ins_dis)) |=> (ts0_out == $past(ts0_in)));

    // R5
    badsel_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ts0_stb && cfg.sel > SEL_W'(SA_LAST - SA_FIRST)) |=> (ts0_out == $past(ts0_in)));

    // R3
    en_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ts0_stb && frm_pos[0] && !cfg.en[CW_BITS-1-int'(frm_pos[POS_W-1:1])])
        |=> (ts0_out == $past(ts0_in)));

    // R2
    other_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ts0_stb |=> (((ts0_out ^ $past(ts0_in)) & ~$past(sel_mask(cfg.sel))) == '0));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ts0_stb && frm_pos == '0) |=> $stable(active));

endmodule

bind sa_cw_inserter sa_cw_inserter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ts0_stb     (ts0_stb),
    .frm_pos     (ts0_frm[2:0]),
    .ts0_in      (ts0_in),
    .ts0_out     (ts0_out),
    .ts0_out_vld (ts0_out_vld),
    .cfg         (cfg_q),
    .active      (cw_active)
);

// File: tb/sa_cw_inserter_bench.sv
module sa_cw_inserter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ts0_stb = 1'b0;
    logic [3:0] ts0_frm = '0;
    logic [7:0] ts0_in = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [4:0] reg_wdata = '0;
    logic [7:0] ts0_out;
    logic       ts0_out_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench-side view of the programmed state
    logic [3:0] act_b = '0;
    logic [3:0] en_b  = '0;
    logic [2:0] sel_b = '0;
    logic       fd_b  = 1'b0;
    logic       id_b  = 1'b0;

    always #2 clk = ~clk;

    sa_cw_inserter u_sa_cw_inserter (
        .clk         (clk),
        .rst         (rst),
        .ts0_stb     (ts0_stb),
        .ts0_frm     (ts0_frm),
        .ts0_in      (ts0_in),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .ts0_out     (ts0_out),
        .ts0_out_vld (ts0_out_vld)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [3:0] f, input logic [7:0] din);
        logic [7:0] r;
        int i;
        r = din;
        if (!f[0] || fd_b || id_b || sel_b > 3'd4) return r;
        i = 3 - int'(f[2:1]);
        if (!en_b[i]) return r;
        r[4 - int'(sel_b)] = act_b[i];
        return r;
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_ctrl(input logic [2:0] s, input logic fd, input logic id);
        sel_b = s; fd_b = fd; id_b = id;
        reg_write(2'd2, {id, fd, s});
    endtask

    task automatic set_en(input logic [3:0] e);
        en_b = e;
        reg_write(2'd1, {1'b0, e});
    endtask

    // one strobe, optionally with a same-cycle codeword write; R11 checked here
    task automatic tx(input logic [3:0] f, input logic [7:0] din, input bit with_wr,
                      input logic [3:0] cw, output logic [7:0] dout);
        @(negedge clk);
        check("R11 idle vld", {7'd0, ts0_out_vld}, 8'd0);
        ts0_stb = 1'b1; ts0_frm = f; ts0_in = din;
        if (with_wr) begin
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {1'b0, cw};
        end
        @(negedge clk);
        ts0_stb = 1'b0; reg_wr = 1'b0;
        check("R11 vld after strobe", {7'd0, ts0_out_vld}, 8'd1);
        dout = ts0_out;
    endtask

    task automatic run(input int lo, input int hi, input logic [7:0] din, input string req);
        for (int f = lo; f <= hi; f++) begin
            logic [7:0] d;
            tx(4'(f), din, 1'b0, 4'd0, d);
            check((f % 2 == 0) ? "R4 even frame" : req, d, model(4'(f), din));
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R1 reset out", ts0_out, 8'h00);
        check("R1 reset vld", {7'd0, ts0_out_vld}, 8'd0);
        rst = 1'b0;
        run(1, 1, 8'h00, "R1 pass after reset");
        run(1, 1, 8'hFF, "R1 pass after reset");
    endtask

    task automatic t_basic();
        reg_write(2'd0, 5'b01010);
        set_en(4'b1111);
        set_ctrl(3'd0, 1'b0, 1'b0);
        run(8, 8, 8'hFF, "R2");
        act_b = 4'b1010;
        run(9, 15, 8'hFF, "R2");
        run(0, 7, 8'h00, "R2");
    endtask

    task automatic t_enables();
        set_en(4'b0101);
        set_ctrl(3'd2, 1'b0, 1'b0);
        run(0, 7, 8'hFF, "R3");
    endtask

    task automatic t_sel();
        set_en(4'b1111);
        reg_write(2'd0, 5'b01111);
        run(8, 8, 8'h00, "R5");
        act_b = 4'b1111;
        for (int s = 0; s < 8; s++) begin
            set_ctrl(3'(s), 1'b0, 1'b0);
            run(1, 1, 8'h00, "R5");
        end
    endtask

    task automatic t_dis();
        set_ctrl(3'd0, 1'b1, 1'b0);
        run(1, 1, 8'h00, "R6");
        set_ctrl(3'd0, 1'b0, 1'b1);
        run(1, 1, 8'h00, "R6");
        set_ctrl(3'd0, 1'b1, 1'b1);
        run(1, 1, 8'h00, "R6");
        set_ctrl(3'd0, 1'b0, 1'b0);
        run(1, 1, 8'h00, "R6");
    endtask

    task automatic t_first_half_write();
        run(0, 3, 8'h00, "R7");
        reg_write(2'd0, 5'b00000);
        run(4, 7, 8'h00, "R7 old codeword kept");
        run(8, 8, 8'h00, "R7");
        act_b = 4'b0000;
        run(9, 15, 8'h00, "R7 new codeword");
    endtask

    task automatic t_second_half_write();
        run(0, 11, 8'h00, "R8");
        reg_write(2'd0, 5'b01111);
        run(12, 15, 8'h00, "R8 old codeword kept");
        run(0, 0, 8'h00, "R8");
        act_b = 4'b1111;
        run(1, 7, 8'h00, "R8 new codeword");
    endtask

    task automatic t_collide();
        logic [7:0] d;
        tx(4'd8, 8'h00, 1'b1, 4'b0000, d);
        check("R9 boundary strobe", d, 8'h00);
        act_b = 4'b0000;
        run(9, 15, 8'h00, "R9");
        reg_write(2'd0, 5'b01000);
        reg_write(2'd0, 5'b00100);
        run(0, 0, 8'h00, "R10");
        act_b = 4'b0100;
        run(1, 7, 8'h00, "R10");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_enables();
        t_sel();
        t_dis();
        t_first_half_write();
        t_second_half_write();
        t_collide();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule